// File: doc/BRIEF.md
# Serial Command and Diagnosis Frame Interface

This block is the serial slave that sits in front of an eight-channel low-side switch controller. A host talks to it through a chip-select, a serial clock and a data line in each direction. Every frame is sixteen bits, most significant bit first. While a frame is shifted in, the slave shifts out either a per-channel fault summary or the answer to a read issued in the frame before. Several slaves can share one select line in a chain, because each one passes its input bits on to its output after a sixteen-bit delay.

When chip-select rises, the slave acts on the last sixteen bits it received, but only if the number of clock falls was a nonzero multiple of eight. The two top bits hold the command: status only, read, restore defaults or write. A write to one of the six configuration and output-control registers updates the register outputs that the channel logic uses. Every accepted frame sends a one-cycle pulse that clears the latched fault flags. All serial inputs are sampled by the system clock through synchronizers, so the block lives in one clock domain.

Top module: `spi_frm_top`

## Requirements
- R1: Data is sampled on each falling serial clock edge while select is low, and the output bit changes on each rising edge. The first bit driven out is bit 15 of the word loaded at the falling edge of select.
- R2: While select is high, serial clock and data activity has no effect and `so_oe` is 0. While select is low, `so_oe` is 1.
- R3: When no read answer is pending, the word loaded at the select fall gives channel n in bits 2n+1:2n. The codes are 2'b10 for overload or overtemperature, 2'b00 for short to ground, 2'b01 for open load and 2'b11 for no fault. When a channel has several faults, the code follows that same priority order.
- R4: A frame is acted on only if the count of falling clock edges since select fell is nonzero and a multiple of 8. Any other frame causes no register change, no clear pulse and no pending read, though it still uses up a pending read answer.
- R5: The decoded frame is the last 16 bits received, with the loaded word taking part when fewer than 16 bits arrived. Once the first 16 bits have gone out, the output repeats the input delayed by 16 clocks.
- R6: Command 2'b11 (bits 15:14) writes bits 7:0 to the address in bits 10:8. The writable addresses are 1 (input map), 2 (combine operator), 3 (overload mode), 4 (overtemperature mode), 5 (slew) and 7 (output control). Writes to addresses 0 and 6 have no effect.
- R7: After an accepted command 2'b01, the next frame shifts out {2'b01, 3'b000, address, data}. Address 6 returns `status_in`, address 0 returns 0, and all other addresses return the register. The answering frame can itself carry any command.
- R8: Command 2'b10 restores the defaults (input map 8'h08, all others 8'h00). Command 2'b00 changes no register.
- R9: Each accepted frame raises `flag_clr` for exactly one clock cycle.
- R10: While `rst_n` is low, all registers hold their defaults and any pending read answer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| fault_ovl | input | 8 | Latched overload or overtemperature flag per channel |
| fault_sg | input | 8 | Latched short-to-ground flag per channel |
| fault_ol | input | 8 | Latched open-load flag per channel |
| status_in | input | 8 | Output state monitor, read at address 6 |
| map_o | output | 8 | Input map register |
| bool_o | output | 8 | Combine operator register |
| ovl_cfg_o | output | 8 | Overload mode register |
| ovt_cfg_o | output | 8 | Overtemperature mode register |
| slew_o | output | 8 | Slew register |
| out_ctl_o | output | 8 | Output control register |
| flag_clr | output | 1 | One-cycle pulse that clears the fault flags |

## Verification
Two actions can meet at one select fall: handing out the answer to an earlier read, and starting a frame that carries its own command. Chained reads test this. In them, the answering frame issues a read or a write, and the bench checks both the shifted-out answer and the register change that the new command makes. A second meeting point is an invalid frame that follows a read. That frame must use up the pending answer while leaving the registers and the clear pulse untouched. The bench model captures this by deciding the outgoing word at each select fall, independently of whether that frame is later accepted.

// File: rtl/spi_frm_pkg.sv
`timescale 1ns/1ps
package spi_frm_pkg;
  localparam int FRAME_W  = 16;
  localparam int CMD_W    = 2;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int PAD_W    = FRAME_W - CMD_W - ADDR_W - DATA_W;
  localparam int N_CH     = DATA_W;
  localparam int NUM_ADDR = 1 << ADDR_W;
  localparam int GRAN     = 8;
  localparam int SYNC_STG = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_DIAG  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_RESET = 2'b10,
    CMD_WRITE = 2'b11
  } cmd_e;

  localparam logic [ADDR_W-1:0] ADDR_NONE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MAP    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_OUTCTL = 3'd7;

  localparam logic [1:0] DC_SHORT_GND = 2'b00;
  localparam logic [1:0] DC_OPEN      = 2'b01;
  localparam logic [1:0] DC_OVER      = 2'b10;
  localparam logic [1:0] DC_OK        = 2'b11;

  function automatic logic [DATA_W-1:0] reg_default(input int a);
    return (a == int'(ADDR_MAP)) ? DATA_W'(8'h08) : '0;
  endfunction

  function automatic bit is_writable(input int a);
    return (a != int'(ADDR_NONE)) && (a != int'(ADDR_STATUS));
  endfunction
endpackage

// File: rtl/spi_frm_sync.sv
`timescale 1ns/1ps
module spi_frm_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frm_diag_enc.sv
`timescale 1ns/1ps
module spi_frm_diag_enc
  import spi_frm_pkg::*;
(
  input  logic [N_CH-1:0]   fault_ovl,
  input  logic [N_CH-1:0]   fault_sg,
  input  logic [N_CH-1:0]   fault_ol,
  output logic [2*N_CH-1:0] diag_word
);
  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic [1:0] code;
    always_comb begin
      if (fault_ovl[n])     code = DC_OVER;
      else if (fault_sg[n]) code = DC_SHORT_GND;
      else if (fault_ol[n]) code = DC_OPEN;
      else                  code = DC_OK;
    end
    assign diag_word[2*n +: 2] = code;
  end
endmodule

// File: rtl/spi_frm_shift.sv
`timescale 1ns/1ps
module spi_frm_shift
  import spi_frm_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int GR = GRAN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          si_s,
  input  logic [FW-1:0] load_word,
  output logic          cs_fall,
  output logic          frame_ok,
  output logic [FW-1:0] frame_word,
  output logic          so_q,
  output logic          so_oe
);
  localparam int CNT_W = (GR > 1) ? $clog2(GR) : 1;

  logic          cs_d_q, sclk_d_q;
  logic          cs_rise, sclk_rise, sclk_fall;
  logic [FW-1:0] sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic          so_d;

  assign cs_fall   = cs_d_q & ~cs_s;
  assign cs_rise   = ~cs_d_q & cs_s;
  assign sclk_rise = ~sclk_d_q & sclk_s & ~cs_s;
  assign sclk_fall = sclk_d_q & ~sclk_s & ~cs_s;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;
    so_d   = so_q;
    if (cs_fall) begin
      sr_d   = load_word;
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (sclk_fall) begin
      sr_d   = {sr_q[FW-2:0], si_s};
      cnt_d  = cnt_q + 1'b1;
      seen_d = 1'b1;
    end
    if (sclk_rise) so_d = sr_q[FW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q   <= 1'b1;
      sclk_d_q <= 1'b0;
      sr_q     <= '0;
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      so_q     <= 1'b0;
    end else begin
      cs_d_q   <= cs_s;
      sclk_d_q <= sclk_s;
      sr_q     <= sr_d;
      cnt_q    <= cnt_d;
      seen_q   <= seen_d;
      so_q     <= so_d;
    end
  end

  assign frame_ok   = cs_rise & seen_q & (cnt_q == '0);
  assign frame_word = sr_q;
  assign so_oe      = ~cs_s;

  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(sr_q) && $stable(so_q));
endmodule

// File: rtl/spi_frm_regs.sv
`timescale 1ns/1ps
module spi_frm_regs
  import spi_frm_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frame_ok,
  input  logic [FRAME_W-1:0]                frame_word,
  input  logic                              cs_fall,
  input  logic [FRAME_W-1:0]                diag_word,
  input  logic [DATA_W-1:0]                 status_in,
  output logic [NUM_ADDR-1:0][DATA_W-1:0]   regs_o,
  output logic [FRAME_W-1:0]                load_word,
  output logic                              flag_clr
);
  cmd_e               cmd;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  logic               rd_pend_q, rd_pend_d;
  logic [ADDR_W-1:0]  rd_addr_q, rd_addr_d;
  logic [DATA_W-1:0]  rd_data;
  logic               clr_q;

  assign cmd  = cmd_e'(frame_word[FRAME_W-1 -: CMD_W]);
  assign addr = frame_word[DATA_W +: ADDR_W];
  assign data = frame_word[DATA_W-1:0];

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_reg
    if (is_writable(a)) begin : g_rw
      logic [DATA_W-1:0] q, d;
      always_comb begin
        d = q;
        if (frame_ok) begin
          if (cmd == CMD_RESET)
            d = reg_default(a);
          else if (cmd == CMD_WRITE && addr == ADDR_W'(a))
            d = data;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reg_default(a);
        else        q <= d;
      end
      assign regs_o[a] = q;
    end else begin : g_none
      assign regs_o[a] = '0;
    end
  end

  always_comb begin
    rd_pend_d = rd_pend_q;
    rd_addr_d = rd_addr_q;
    if (cs_fall) rd_pend_d = 1'b0;
    if (frame_ok && cmd == CMD_READ) begin
      rd_pend_d = 1'b1;
      rd_addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      clr_q     <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      rd_addr_q <= rd_addr_d;
      clr_q     <= frame_ok;
    end
  end

  assign rd_data   = (rd_addr_q == ADDR_STATUS) ? status_in : regs_o[rd_addr_q];
  assign load_word = rd_pend_q ? {CMD_READ, {PAD_W{1'b0}}, rd_addr_q, rd_data} : diag_word;
  assign flag_clr  = clr_q;

  assert_ro_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && cmd == CMD_WRITE && (addr == ADDR_STATUS || addr == ADDR_NONE)
      |=> $stable(regs_o));
  assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && cmd == CMD_RESET
      |=> regs_o[ADDR_MAP] == reg_default(int'(ADDR_MAP)) && regs_o[ADDR_OUTCTL] == '0);
  assert_diag_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && cmd == CMD_DIAG |=> $stable(regs_o));
  assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr);
endmodule

// File: rtl/spi_frm_top.sv
`timescale 1ns/1ps
module spi_frm_top
  import spi_frm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [N_CH-1:0]   fault_ovl,
  input  logic [N_CH-1:0]   fault_sg,
  input  logic [N_CH-1:0]   fault_ol,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] map_o,
  output logic [DATA_W-1:0] bool_o,
  output logic [DATA_W-1:0] ovl_cfg_o,
  output logic [DATA_W-1:0] ovt_cfg_o,
  output logic [DATA_W-1:0] slew_o,
  output logic [DATA_W-1:0] out_ctl_o,
  output logic              flag_clr
);
  logic                            rst_sn;
  logic [2:0]                      pins_s;
  logic                            cs_fall, frame_ok;
  logic [FRAME_W-1:0]              frame_word, load_word, diag_word;
  logic [NUM_ADDR-1:0][DATA_W-1:0] regs;

  spi_frm_sync #(.W(1), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn));

  spi_frm_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_sn), .d({cs_n, sclk, si}), .q(pins_s));

  spi_frm_diag_enc u_diag (
    .fault_ovl(fault_ovl), .fault_sg(fault_sg), .fault_ol(fault_ol), .diag_word(diag_word));

  spi_frm_shift u_shift (
    .clk(clk), .rst_n(rst_sn), .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .si_s(pins_s[0]),
    .load_word(load_word), .cs_fall(cs_fall), .frame_ok(frame_ok),
    .frame_word(frame_word), .so_q(so), .so_oe(so_oe));

  spi_frm_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .frame_ok(frame_ok), .frame_word(frame_word),
    .cs_fall(cs_fall), .diag_word(diag_word), .status_in(status_in),
    .regs_o(regs), .load_word(load_word), .flag_clr(flag_clr));

  assign map_o     = regs[1];
  assign bool_o    = regs[2];
  assign ovl_cfg_o = regs[3];
  assign ovt_cfg_o = regs[4];
  assign slew_o    = regs[5];
  assign out_ctl_o = regs[7];
endmodule

// File: tb/spi_frm_top_tb.sv
`timescale 1ns/1ps
module spi_frm_top_tb;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, si;
  logic so, so_oe, flag_clr;
  logic [7:0] fault_ovl, fault_sg, fault_ol, status_in;
  logic [7:0] map_o, bool_o, ovl_cfg_o, ovt_cfg_o, slew_o, out_ctl_o;

  int compared = 0;
  int mismatched = 0;
  bit chk_en = 0;
  bit done = 0;

  logic [7:0] exp_r [8];
  bit         pend;
  logic [2:0] paddr;
  logic       exp_clr;

  always #5 clk = ~clk;

  spi_frm_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .so(so), .so_oe(so_oe),
    .fault_ovl(fault_ovl), .fault_sg(fault_sg), .fault_ol(fault_ol), .status_in(status_in),
    .map_o(map_o), .bool_o(bool_o), .ovl_cfg_o(ovl_cfg_o), .ovt_cfg_o(ovt_cfg_o),
    .slew_o(slew_o), .out_ctl_o(out_ctl_o), .flag_clr(flag_clr));

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_defaults();
    for (int a = 0; a < 8; a++) exp_r[a] = 8'h00;
    exp_r[1] = 8'h08;
    pend = 0;
    exp_clr = 0;
  endfunction

  function automatic logic [15:0] diag_model();
    logic [15:0] w;
    for (int n = 0; n < 8; n++)
      w[2*n +: 2] = fault_ovl[n] ? 2'b10 : fault_sg[n] ? 2'b00 : fault_ol[n] ? 2'b01 : 2'b11;
    return w;
  endfunction

  function automatic logic [15:0] fw(input logic [1:0] c, input logic [2:0] a, input logic [7:0] d);
    return {c, 3'b000, a, d};
  endfunction

  // per-clock comparison of register outputs and clear pulse
  always @(negedge clk) begin
    if (chk_en && !done) begin
      cmp("R6 R8 R10 map", {24'h0, map_o}, {24'h0, exp_r[1]});
      cmp("R6 R8 R10 bool", {24'h0, bool_o}, {24'h0, exp_r[2]});
      cmp("R6 R8 R10 ovl", {24'h0, ovl_cfg_o}, {24'h0, exp_r[3]});
      cmp("R6 R8 R10 ovt", {24'h0, ovt_cfg_o}, {24'h0, exp_r[4]});
      cmp("R6 R8 R10 slew", {24'h0, slew_o}, {24'h0, exp_r[5]});
      cmp("R6 R8 R10 outctl", {24'h0, out_ctl_o}, {24'h0, exp_r[7]});
      cmp("R9 flag_clr", {31'h0, flag_clr}, {31'h0, exp_clr});
    end
  end

  task automatic run_frame(input logic [63:0] bits, input int n, input string tag);
    logic [15:0] word, fr;
    logic [7:0]  rv;
    if (pend) begin
      rv = (paddr == 3'd6) ? status_in : exp_r[paddr];
      word = {2'b01, 3'b000, paddr, rv};
    end else begin
      word = diag_model();
    end
    pend = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sclk = 1'b1;
      si = bits[n-1-k];
      repeat (4) @(posedge clk);
      @(negedge clk);
      if (k < 16) cmp({tag, " R1 so"}, {31'h0, so}, {31'h0, word[15-k]});
      else        cmp("R5 so daisy", {31'h0, so}, {31'h0, bits[n-1-(k-16)]});
      cmp("R2 so_oe active", {31'h0, so_oe}, 32'h1);
      sclk = 1'b0;
      repeat (4) @(posedge clk);
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(posedge clk);
    if (n > 0 && (n % 8) == 0) begin
      fr = (n >= 16) ? bits[15:0] : 16'((32'(word) << n) | 32'(bits[15:0]));
      exp_clr = 1'b1;
      case (fr[15:14])
        2'b11: if (fr[10:8] != 3'd0 && fr[10:8] != 3'd6) exp_r[fr[10:8]] = fr[7:0];
        2'b01: begin pend = 1; paddr = fr[10:8]; end
        2'b10: begin for (int a = 0; a < 8; a++) exp_r[a] = 8'h00; exp_r[1] = 8'h08; end
        default: ;
      endcase
    end
    @(posedge clk) exp_clr = 1'b0;
    @(negedge clk) cmp("R2 so_oe idle", {31'h0, so_oe}, 32'h0);
    repeat (2) @(posedge clk);
  endtask

  task automatic hw_reset();
    @(posedge clk) #1 rst_n = 1'b0;
    model_defaults();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b1; cs_n = 1'b1; sclk = 1'b0; si = 1'b0;
    fault_ovl = '0; fault_sg = '0; fault_ol = '0; status_in = 8'h00;
    model_defaults();
    #1 rst_n = 1'b0;
    chk_en = 1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) cmp("R10 reset map default", {24'h0, map_o}, 32'h08);

    // R3 priority: ch0 ovl+sg -> 10, ch1 sg+ol -> 00, ch2 ol -> 01
    fault_ovl = 8'h01; fault_sg = 8'h03; fault_ol = 8'h06;
    run_frame(64'(fw(2'b11, 3'd1, 8'h5A)), 16, "R3 diag prio");
    fault_ovl = 8'h80; fault_sg = 8'h10; fault_ol = 8'h21;
    run_frame(64'(fw(2'b11, 3'd7, 8'hC3)), 16, "R3 diag");
    run_frame(64'(fw(2'b11, 3'd2, 8'h11)), 16, "R3 diag");
    fault_ovl = 8'h00; fault_sg = 8'h00; fault_ol = 8'hFF;
    run_frame(64'(fw(2'b11, 3'd3, 8'h22)), 16, "R3 diag all open");
    fault_ol = 8'h00;
    run_frame(64'(fw(2'b11, 3'd4, 8'h44)), 16, "R3 diag none");
    run_frame(64'(fw(2'b11, 3'd5, 8'h88)), 16, "R6 write");

    // R7 read chain: the answer frame carries a new command
    run_frame(64'(fw(2'b01, 3'd7, 8'h00)), 16, "R7 read issue");
    status_in = 8'h9C;
    run_frame(64'(fw(2'b01, 3'd6, 8'h00)), 16, "R7 answer outctl");
    run_frame(64'(fw(2'b11, 3'd5, 8'h3C)), 16, "R7 answer status");
    run_frame(64'(fw(2'b01, 3'd5, 8'h00)), 16, "R7 read slew");
    run_frame(64'(fw(2'b00, 3'd5, 8'hFF)), 16, "R7 answer slew R8 diag cmd");

    // R6 ignored addresses
    run_frame(64'(fw(2'b11, 3'd6, 8'hFF)), 16, "R6 write status");
    run_frame(64'(fw(2'b11, 3'd0, 8'h77)), 16, "R6 write addr0");
    run_frame(64'(fw(2'b01, 3'd0, 8'h00)), 16, "R6 read addr0");
    run_frame(64'(fw(2'b00, 3'd0, 8'h00)), 16, "R7 answer addr0");

    // R4 invalid lengths
    run_frame(64'(fw(2'b11, 3'd7, 8'h00)), 12, "R4 12 bit");
    run_frame(64'h0, 0, "R4 zero bit");
    run_frame(64'(fw(2'b01, 3'd1, 8'h00) >> 1), 15, "R4 15 bit read");
    run_frame(64'(fw(2'b00, 3'd0, 8'h00)), 16, "R4 no answer");

    // R5 longer frames and daisy chain
    run_frame({40'h0, 8'hFF, fw(2'b11, 3'd2, 8'hA5)}, 24, "R5 24 bit");
    run_frame({32'h0, fw(2'b11, 3'd3, 8'hFF), fw(2'b11, 3'd3, 8'h5B)}, 32, "R5 32 bit");
    // 8-bit frame: word FFFF loaded, frame = {FF, 96} -> write out_ctl 96
    run_frame(64'h96, 8, "R4 R5 8 bit");

    // R4: an invalid frame still consumes a pending answer
    run_frame(64'(fw(2'b01, 3'd7, 8'h00)), 16, "R7 read");
    run_frame(64'hA, 4, "R4 R7 answer in bad frame");
    run_frame(64'(fw(2'b00, 3'd0, 8'h00)), 16, "R4 answer used");

    // R2: clock and data while select is high
    for (int t = 0; t < 10; t++) begin
      @(negedge clk) begin sclk = ~sclk; si = ~si; end
      repeat (3) @(posedge clk);
    end
    @(negedge clk) begin sclk = 1'b0; si = 1'b0; end
    repeat (4) @(posedge clk);
    run_frame(64'(fw(2'b11, 3'd4, 8'h0F)), 16, "R2 after idle clocks");

    // R8 restore defaults
    run_frame(64'(fw(2'b10, 3'd0, 8'h00)), 16, "R8 reset cmd");
    run_frame(64'(fw(2'b11, 3'd7, 8'h3E)), 16, "R8 post reset");

    // R10 hardware reset drops a pending answer
    run_frame(64'(fw(2'b01, 3'd7, 8'h00)), 16, "R10 read before reset");
    hw_reset();
    run_frame(64'(fw(2'b00, 3'd0, 8'h00)), 16, "R10 diag after reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule